// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This unit sits beside the decode stage of an in-order five-stage pipeline. Each cycle it compares the destination index of the instruction now in execute with the source indices of the instruction now in decode. When the instruction in execute is a load and its destination is one of those sources, the loaded value does not exist yet and cannot be forwarded. The unit then freezes the program counter and the fetch/decode register for one cycle. At the same time it zeroes the control bundle going into execute, so the stages behind the stall keep moving and carry an empty slot.

After the one-cycle stall, the dependent instruction moves on. It then gets the load data from the write-back side through the forwarding network, which is not part of this unit. A small internal flag records that the previous cycle was a stall cycle. This keeps each detected hazard to exactly one cycle and lets detection start again on the following cycle, so chains of loads are handled in sequence. Register zero is hard-wired and is never treated as a live dependency.

Top module: `ldu_stall_unit`

## Requirements
- R1: When `ex_mem_rd` is 1, `ex_rt` is nonzero, `ex_rt` equals `id_rs`, and the previous cycle was not a stall cycle, then in the same cycle `pc_we` is 0, `ifid_we` is 0 and `bubble` is 1.
- R2: The same stall as in R1 occurs when `ex_rt` (nonzero) equals `id_rt` instead of `id_rs`.
- R3: When `ex_mem_rd` is 0, no stall occurs, whatever index values are presented.
- R4: When `ex_rt` is 0 (register zero), no stall occurs, even if `ex_mem_rd` is 1 and the decode indices are also 0.
- R5: When no stall occurs, `pc_we` and `ifid_we` are 1, `bubble` is 0, and `ex_ctrl` equals `id_ctrl` bit for bit.
- R6: During a stall cycle, `ex_ctrl` is all zeros. In particular, bit 0 (register write), bit 1 (memory read) and bit 2 (memory write) are all 0.
- R7: A stall lasts exactly one cycle. In the cycle after a stall cycle, `bubble` is 0 whatever the inputs are. In the cycle after that, a hazard can stall again.
- R8: Reset (synchronous, active low) clears the record of a previous stall. The first cycle after reset with idle inputs shows `pc_we`=1, `ifid_we`=1, `bubble`=0, and a hazard presented in that first cycle stalls.
- R9: `pc_we` and `ifid_we` always carry the same value, and that value is always the inverse of `bubble`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ex_mem_rd | input | 1 | Memory-read control bit held in the decode/execute register |
| ex_rt | input | REG_W | Destination (rt) index held in the decode/execute register |
| id_rs | input | REG_W | First source index held in the fetch/decode register |
| id_rt | input | REG_W | Second source index held in the fetch/decode register |
| id_ctrl | input | CTRL_W | Control bundle produced by the decoder for the instruction in decode |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | High while an empty slot is being inserted into execute |
| ex_ctrl | output | CTRL_W | Control bundle entering the decode/execute register, zeroed during a bubble |

## Verification
The assertions assume that the index and control inputs change only between clock edges. They also assume that each input pattern stands for one real pipeline cycle, so "the cycle after a stall" has a meaning. The testbench applies every pattern on the falling edge and samples a nanosecond later. Between independent scenarios it inserts an idle cycle with the memory-read bit clear, so each test begins from a cycle that was not a stall. Load-chain patterns are applied in the order a real pipeline would present them, with a bubble cycle between the two loads.

// File: rtl/ldu_pkg.sv
// Package: shared constants for the load-use stall unit.
// Assumes the control bundle keeps its side-effect bits in the low positions.
package ldu_pkg;
    localparam int unsigned NUM_SRC     = 2;  // decode-stage source operands compared
    localparam int unsigned CBIT_REG_WR = 0;  // register-write bit in control bundle
    localparam int unsigned CBIT_MEM_RD = 1;  // memory-read bit in control bundle
    localparam int unsigned CBIT_MEM_WR = 2;  // memory-write bit in control bundle
endpackage

// File: rtl/ldu_src_match.sv
// Module: compares one decode-stage source index against the destination
// of the load in execute. Assumes indices are plain binary register numbers.
// ZERO_EXEMPT picks whether register zero is treated as never written.
module ldu_src_match #(
    parameter int unsigned REG_W       = 5,
    parameter bit          ZERO_EXEMPT = 1'b1
) (
    input  logic             ld_valid,
    input  logic [REG_W-1:0] ld_dst,
    input  logic [REG_W-1:0] src_idx,
    output logic             hit
);
    logic dst_live;

    generate
        if (ZERO_EXEMPT) begin : g_zero_exempt
            // Purpose: register zero carries no live value, so it never matches.
            always_comb dst_live = ld_valid && (ld_dst != '0);
        end else begin : g_zero_plain
            // Purpose: every destination index counts as live.
            always_comb dst_live = ld_valid;
        end
    endgenerate

    // Purpose: flag a dependency on the pending load result.
    always_comb hit = dst_live && (ld_dst == src_idx);
endmodule

// File: rtl/ldu_ctrl_gate.sv
// Module: passes the decoded control bundle into execute, or forces it
// to zero while a bubble is inserted. Assumes an all-zero bundle is a no-op.
module ldu_ctrl_gate #(
    parameter int unsigned CTRL_W = 8
) (
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              kill,
    output logic [CTRL_W-1:0] ctrl_out
);
    genvar b;
    generate
        for (b = 0; b < CTRL_W; b++) begin : g_bit
            // Purpose: clear this control bit when the slot is killed.
            assign ctrl_out[b] = ctrl_in[b] & ~kill;
        end
    endgenerate
endmodule

// File: rtl/ldu_stall_unit.sv
// Module: load-use hazard stall unit. Freezes PC and the fetch/decode
// register for one cycle and zeroes the control entering execute when
// the decode instruction reads the destination of a load in execute.
// Assumes inputs are stable between edges; reset is synchronous, active low.
module ldu_stall_unit
    import ldu_pkg::*;
#(
    parameter int unsigned REG_W       = 5,
    parameter int unsigned CTRL_W      = 8,
    parameter bit          ZERO_EXEMPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_mem_rd,
    input  logic [REG_W-1:0]  ex_rt,
    input  logic [REG_W-1:0]  id_rs,
    input  logic [REG_W-1:0]  id_rt,
    input  logic [CTRL_W-1:0] id_ctrl,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble,
    output logic [CTRL_W-1:0] ex_ctrl
);
    logic [REG_W-1:0]   src_idx [NUM_SRC];
    logic [NUM_SRC-1:0] src_hit;
    logic               dep_found;
    logic               stall_q;
    logic               stall_now;

    // Purpose: collect the decode-stage source indices in a fixed order.
    always_comb begin
        src_idx[0] = id_rs;
        src_idx[1] = id_rt;
    end

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            ldu_src_match #(
                .REG_W       (REG_W),
                .ZERO_EXEMPT (ZERO_EXEMPT)
            ) match_i (
                .ld_valid (ex_mem_rd),
                .ld_dst   (ex_rt),
                .src_idx  (src_idx[s]),
                .hit      (src_hit[s])
            );
        end
    endgenerate

    // Purpose: stall only on a fresh dependency, never twice in a row.
    always_comb begin
        dep_found = |src_hit;
        stall_now = dep_found && !stall_q;
    end

    // Purpose: remember that this cycle was a stall cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= stall_now;
    end

    // Purpose: drive the hold enables and the bubble request.
    always_comb begin
        pc_we   = !stall_now;
        ifid_we = !stall_now;
        bubble  = stall_now;
    end

    ldu_ctrl_gate #(
        .CTRL_W (CTRL_W)
    ) gate_i (
        .ctrl_in  (id_ctrl),
        .kill     (stall_now),
        .ctrl_out (ex_ctrl)
    );

    // R1: rs dependency on a live load after a non-stall cycle must stall
    a_r1_rs_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_rd && ex_rt != '0 && ex_rt == id_rs && !stall_q) |-> (bubble && !pc_we));
    // R2: rt dependency likewise
    a_r2_rt_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_rd && ex_rt != '0 && ex_rt == id_rt && !stall_q) |-> (bubble && !ifid_we));
    // R3: no load, no stall
    a_r3_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_rd |-> (pc_we && !bubble));
    // R5: pass-through of control when not stalling
    a_r5_pass_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |-> (ex_ctrl == id_ctrl));
    // R6: side-effect bits cleared during a bubble
    a_r6_quiet_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (ex_ctrl[CBIT_REG_WR] == 1'b0 && ex_ctrl[CBIT_MEM_RD] == 1'b0
                    && ex_ctrl[CBIT_MEM_WR] == 1'b0 && ex_ctrl == '0));
    // R7: a stall never lasts two cycles
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);
    // R9: enables agree and oppose the bubble
    a_r9_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (pc_we != bubble));
endmodule

// File: tb/ldu_stall_unit_tb_top.sv
// Bench: directed tests of the load-use stall unit, one task per scenario.
module ldu_stall_unit_tb_top;
    localparam int unsigned REG_W  = 5;
    localparam int unsigned CTRL_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ex_mem_rd = 1'b0;
    logic [REG_W-1:0]  ex_rt = '0;
    logic [REG_W-1:0]  id_rs = '0;
    logic [REG_W-1:0]  id_rt = '0;
    logic [CTRL_W-1:0] id_ctrl = '0;
    logic              pc_we;
    logic              ifid_we;
    logic              bubble;
    logic [CTRL_W-1:0] ex_ctrl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ldu_stall_unit #(.REG_W(REG_W), .CTRL_W(CTRL_W), .ZERO_EXEMPT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ex_mem_rd(ex_mem_rd), .ex_rt(ex_rt),
        .id_rs(id_rs), .id_rt(id_rt), .id_ctrl(id_ctrl),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble), .ex_ctrl(ex_ctrl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one cycle's pattern on the falling edge, then let it settle.
    task automatic drive(input logic mr, input logic [REG_W-1:0] xrt,
                         input logic [REG_W-1:0] rs, input logic [REG_W-1:0] rt,
                         input logic [CTRL_W-1:0] ctl);
        @(negedge clk);
        ex_mem_rd = mr; ex_rt = xrt; id_rs = rs; id_rt = rt; id_ctrl = ctl;
        #1;
    endtask

    task automatic expect_stall(input string tag, input logic stall, input logic [CTRL_W-1:0] ctl);
        check({tag, " pc_we"},   32'(pc_we),   32'(!stall));
        check({tag, " ifid_we"}, 32'(ifid_we), 32'(!stall));
        check({tag, " bubble"},  32'(bubble),  32'(stall));
        check({tag, " ex_ctrl"}, 32'(ex_ctrl), stall ? 32'h0 : 32'(ctl));
    endtask

    task automatic idle();
        drive(1'b0, 5'd0, 5'd0, 5'd0, 8'h00);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) idle();
        @(negedge clk); rst_n = 1'b1;
        ex_mem_rd = 1'b0; id_ctrl = 8'h11; #1;
        expect_stall("R8 idle after reset", 1'b0, 8'h11);
    endtask

    task automatic t_rs_hazard();
        idle();
        drive(1'b1, 5'd5, 5'd5, 5'd7, 8'hA7);
        expect_stall("R1 rs match", 1'b1, 8'hA7);
        check("R6 side bits", 32'(ex_ctrl[2:0]), 32'h0);
        check("R9 enables equal", 32'(pc_we == ifid_we), 32'h1);
    endtask

    task automatic t_rt_hazard();
        idle();
        drive(1'b1, 5'd9, 5'd3, 5'd9, 8'hFF);
        expect_stall("R2 rt match", 1'b1, 8'hFF);
    endtask

    task automatic t_no_memread();
        idle();
        drive(1'b0, 5'd5, 5'd5, 5'd5, 8'h3C);
        expect_stall("R3 no load", 1'b0, 8'h3C);
    endtask

    task automatic t_zero_reg();
        idle();
        drive(1'b1, 5'd0, 5'd0, 5'd0, 8'h07);
        expect_stall("R4 zero reg", 1'b0, 8'h07);
    endtask

    task automatic t_independent();
        idle();
        drive(1'b1, 5'd4, 5'd6, 5'd7, 8'h5A);
        expect_stall("R5 independent", 1'b0, 8'h5A);
    endtask

    task automatic t_one_cycle();
        idle();
        drive(1'b1, 5'd12, 5'd12, 5'd12, 8'h0F);
        expect_stall("R7 first cycle", 1'b1, 8'h0F);
        drive(1'b1, 5'd12, 5'd12, 5'd12, 8'h0F);
        expect_stall("R7 held inputs released", 1'b0, 8'h0F);
        drive(1'b1, 5'd12, 5'd12, 5'd12, 8'h0F);
        expect_stall("R7 re-armed", 1'b1, 8'h0F);
    endtask

    task automatic t_back_to_back();
        idle();
        drive(1'b1, 5'd1, 5'd1, 5'd2, 8'h07);   // load1 in EX, load2 reads r1
        expect_stall("R7 chain stall one", 1'b1, 8'h07);
        drive(1'b0, 5'd0, 5'd1, 5'd2, 8'h07);   // bubble in EX, load2 still in ID
        expect_stall("R7 chain bubble cycle", 1'b0, 8'h07);
        drive(1'b1, 5'd2, 5'd2, 5'd3, 8'h21);   // load2 in EX, add reads r2
        expect_stall("R7 chain stall two", 1'b1, 8'h21);
    endtask

    task automatic t_reset_clears();
        idle();
        drive(1'b1, 5'd8, 5'd8, 5'd0, 8'h02);
        expect_stall("R8 pre-reset stall", 1'b1, 8'h02);
        @(negedge clk); rst_n = 1'b0; ex_mem_rd = 1'b0; #1;
        @(negedge clk); rst_n = 1'b1;
        ex_mem_rd = 1'b1; ex_rt = 5'd8; id_rs = 5'd8; id_ctrl = 8'h02; #1;
        expect_stall("R8 hazard right after reset", 1'b1, 8'h02);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rs_hazard();
        t_rt_hazard();
        t_no_memread();
        t_zero_reg();
        t_independent();
        t_one_cycle();
        t_back_to_back();
        t_reset_clears();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule